// File: doc/BRIEF.md
# Sequential Arithmetic Left Shift Unit with Condition Codes

This block executes the register form of an arithmetic left shift on a data register. It also produces the five condition codes of a classic 16/32-bit CISC processor: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The host presents a 16-bit opcode, the destination register value, the value of the register that may supply the count, and the current flags. It then pulses `start`. The unit decodes the operand size and the shift count, and shifts the operand one bit per clock. It finishes with a single-cycle `done` pulse. With that pulse it presents the written-back register value, the new flags and the instruction's cycle cost.

Because the shift moves one bit at a time, the overflow flag records every change of the operand's sign bit, not only the final one. Counts equal to or larger than the operand width need no special handling. A zero count follows its own flag rules. Opcodes of neither shift form are reported as illegal and change nothing.

Top module: `asl_seq_unit`

## Requirements
- R1: In the immediate-count form (opcode bits 15..12 = 1110, bit 8 = 1, bits 5..3 = 000), opcode bits 11..9 give the shift count, and a value of 0 in that field means a count of 8.
- R2: In the register-count form (bits 15..12 = 1110, bit 8 = 1, bits 5..3 = 100), the count is `cnt_src` AND 63, which gives 0 to 63.
- R3: Opcode bits 7..6 select the operand width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. Only the low operand-width bits of `result` are shifted. Higher register bits pass through unchanged.
- R4: V is set when the operand's top bit changes on any single-bit step, and it stays set for the rest of the instruction.
- R5: The flags are packed as `flags` bit 4 = X, 3 = N, 2 = Z, 1 = V, 0 = C. After a nonzero count, X and C both equal the last bit shifted out of the operand's top, N is the result's top operand bit, and Z is 1 when the operand-width result is zero.
- R6: With a zero count the register is unchanged, X keeps its incoming value, V and C are 0, and N and Z reflect the operand.
- R7: `cycles` is 2 × count + 4 for 32-bit operands and 2 × count + 2 for 8- and 16-bit operands.
- R8: A count equal to the operand width leaves a zero operand and C equal to the original bit 0. A larger count leaves a zero operand and C = 0.
- R9: An opcode matching neither form, or carrying width code 3, sets `illegal`. The result equals `dst_val`, the flags equal `flags_in`, and `cycles` is 0.
- R10: Reset clears `busy` and `done`. A `start` while busy is ignored. `done` is high for exactly one clock, and the outputs hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opcode | input | 16 | Instruction word |
| dst_val | input | REG_W | Destination register value |
| cnt_src | input | REG_W | Register value that supplies a register count |
| flags_in | input | 5 | Incoming X,N,Z,V,C |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Opcode was not a recognised shift form |
| result | output | REG_W | Written-back register value |
| flags_out | output | 5 | Updated X,N,Z,V,C |
| cycles | output | CYC_W | Instruction cycle cost |

## Verification
The bench uses the default parameters: a 32-bit register, a 6-bit count mask and an 8-bit cycle field. This lets register counts reach 63, which exceeds every operand width, so the equal-to-width and beyond-width carry rules are both reachable. The largest cost, 130 cycles, still fits the cycle field. The 32-bit register also leaves 24 and 16 passthrough bits above the byte and word operands, so writes into those upper bits become visible.

// File: rtl/asl_pkg.sv
package asl_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_NONE = 2'd3
   } asl_size_e;

   localparam int FLAG_W = 5;
   localparam int FL_X   = 4;
   localparam int FL_N   = 3;
   localparam int FL_Z   = 2;
   localparam int FL_V   = 1;
   localparam int FL_C   = 0;
   localparam int LANES  = 3;

   // Sign and zero of the operand-sized low part of a value.
   function automatic logic [1:0] sized_nz(input logic [31:0] v, input asl_size_e s);
      case (s)
         SZ_BYTE: return {v[7],  v[7:0]  == 8'd0};
         SZ_WORD: return {v[15], v[15:0] == 16'd0};
         default: return {v[31], v       == 32'd0};
      endcase
   endfunction
endpackage

// File: rtl/asl_decode.sv
module asl_decode
   import asl_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic [15:0]      opcode,
   input  logic [CNT_W-1:0] cnt_reg,
   output logic             legal,
   output asl_size_e        size,
   output logic [CNT_W-1:0] count
);
   localparam logic [3:0] GROUP    = 4'hE;
   localparam logic [2:0] MODE_IMM = 3'b000;
   localparam logic [2:0] MODE_REG = 3'b100;

   initial begin
      assert (CNT_W >= 4) else $error("CNT_W must hold a count of 8");
   end

   logic unused_rrr;
   assign unused_rrr = ^opcode[2:0];

   logic mode_ok;
   always_comb begin
      size    = asl_size_e'(opcode[7:6]);
      mode_ok = (opcode[5:3] == MODE_IMM) || (opcode[5:3] == MODE_REG);
      legal   = (opcode[15:12] == GROUP) && opcode[8] && mode_ok && (size != SZ_NONE);
      if (opcode[5])
         count = cnt_reg;
      else if (opcode[11:9] == 3'd0)
         count = CNT_W'(8);
      else
         count = CNT_W'(opcode[11:9]);
   end
endmodule

// File: rtl/asl_step.sv
module asl_step
   import asl_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  asl_size_e        size,
   input  logic [REG_W-1:0] val_in,
   output logic [REG_W-1:0] val_out,
   output logic             bit_out,
   output logic             msb_flip
);
   initial begin
      assert (REG_W >= 32) else $error("REG_W must cover the 32-bit operand");
   end

   logic [REG_W-1:0] lane_val  [LANES];
   logic             lane_out  [LANES];
   logic             lane_flip [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int LW = 8 << k;
      if (LW < REG_W) begin : g_part
         assign lane_val[k] = {val_in[REG_W-1:LW], val_in[LW-2:0], 1'b0};
      end else begin : g_full
         assign lane_val[k] = {val_in[LW-2:0], 1'b0};
      end
      assign lane_out[k]  = val_in[LW-1];
      assign lane_flip[k] = val_in[LW-1] ^ val_in[LW-2];
   end

   always_comb begin
      case (size)
         SZ_BYTE: begin val_out = lane_val[0]; bit_out = lane_out[0]; msb_flip = lane_flip[0]; end
         SZ_WORD: begin val_out = lane_val[1]; bit_out = lane_out[1]; msb_flip = lane_flip[1]; end
         default: begin val_out = lane_val[2]; bit_out = lane_out[2]; msb_flip = lane_flip[2]; end
      endcase
   end
endmodule

// File: rtl/asl_cost.sv
module asl_cost
   import asl_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int CYC_W     = 8,
   parameter int LONG_ADD  = 4,
   parameter int SHORT_ADD = 2
) (
   input  logic [CNT_W-1:0] count,
   input  asl_size_e        size,
   output logic [CYC_W-1:0] cycles
);
   localparam int MAX_COST = 2 * ((1 << CNT_W) - 1) + LONG_ADD;

   initial begin
      assert ((1 << CYC_W) > MAX_COST) else $error("CYC_W too narrow for the largest cost");
   end

   always_comb begin
      cycles = CYC_W'({count, 1'b0})
             + ((size == SZ_LONG) ? CYC_W'(LONG_ADD) : CYC_W'(SHORT_ADD));
   end
endmodule

// File: rtl/asl_seq_unit.sv
module asl_seq_unit
   import asl_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int CNT_W     = 6,
   parameter int CYC_W     = 8,
   parameter int LONG_ADD  = 4,
   parameter int SHORT_ADD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       opcode,
   input  logic [REG_W-1:0]  dst_val,
   input  logic [REG_W-1:0]  cnt_src,
   input  logic [4:0]        flags_in,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic [REG_W-1:0]  result,
   output logic [4:0]        flags_out,
   output logic [CYC_W-1:0]  cycles
);
   initial begin
      assert (REG_W >= 32 && CNT_W < REG_W) else $error("bad REG_W / CNT_W");
   end

   logic unused_hi;
   assign unused_hi = ^cnt_src[REG_W-1:CNT_W];

   // decode and cost of the incoming opcode
   logic             dec_legal;
   asl_size_e        dec_size;
   logic [CNT_W-1:0] dec_count;
   logic [CYC_W-1:0] dec_cost;

   asl_decode #(.CNT_W(CNT_W)) u_dec (
      .opcode (opcode),
      .cnt_reg(cnt_src[CNT_W-1:0]),
      .legal  (dec_legal),
      .size   (dec_size),
      .count  (dec_count)
   );

   asl_cost #(.CNT_W(CNT_W), .CYC_W(CYC_W), .LONG_ADD(LONG_ADD), .SHORT_ADD(SHORT_ADD)) u_cost (
      .count (dec_count),
      .size  (dec_size),
      .cycles(dec_cost)
   );

   // working state
   logic             busy_q, done_q, ill_q, zero_q, v_q, c_q, ill_out_q;
   logic [REG_W-1:0] work_q, res_q;
   logic [CNT_W-1:0] cnt_q;
   asl_size_e        size_q;
   logic [4:0]       fin_q, flags_q;
   logic [CYC_W-1:0] cost_q, cyc_q;

   logic [REG_W-1:0] step_val;
   logic             step_out, step_flip;
   logic [1:0]       nz;

   asl_step #(.REG_W(REG_W)) u_step (
      .size    (size_q),
      .val_in  (work_q),
      .val_out (step_val),
      .bit_out (step_out),
      .msb_flip(step_flip)
   );

   assign nz = sized_nz(work_q[31:0], size_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         ill_q     <= 1'b0;
         zero_q    <= 1'b0;
         v_q       <= 1'b0;
         c_q       <= 1'b0;
         ill_out_q <= 1'b0;
         work_q    <= '0;
         res_q     <= '0;
         cnt_q     <= '0;
         size_q    <= SZ_BYTE;
         fin_q     <= '0;
         flags_q   <= '0;
         cost_q    <= '0;
         cyc_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               work_q <= dst_val;
               cnt_q  <= dec_legal ? dec_count : '0;
               size_q <= dec_legal ? dec_size : SZ_LONG;
               zero_q <= (dec_count == '0);
               ill_q  <= !dec_legal;
               v_q    <= 1'b0;
               c_q    <= 1'b0;
               fin_q  <= flags_in;
               cost_q <= dec_cost;
            end
         end else if (cnt_q != '0) begin
            work_q <= step_val;
            v_q    <= v_q | step_flip;
            c_q    <= step_out;
            cnt_q  <= cnt_q - 1'b1;
         end else begin
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            res_q     <= work_q;
            ill_out_q <= ill_q;
            if (ill_q) begin
               flags_q <= fin_q;
               cyc_q   <= '0;
            end else begin
               cyc_q <= cost_q;
               if (zero_q)
                  flags_q <= {fin_q[FL_X], nz[1], nz[0], 1'b0, 1'b0};
               else
                  flags_q <= {c_q, nz[1], nz[0], v_q, c_q};
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign illegal   = ill_out_q;
   assign result    = res_q;
   assign flags_out = flags_q;
   assign cycles    = cyc_q;

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R10: leaving busy always signals completion
   p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   // R10: a start during a run does not disturb the step counter
   p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R4: overflow stays set for the rest of the run
   p_v_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && v_q) |=> v_q);
   // R5: X and C agree after a nonzero count
   p_x_eq_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !ill_out_q && !zero_q) |-> (flags_q[FL_X] == flags_q[FL_C]));
   // R6: zero count clears V and C and keeps X
   p_zero_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !ill_out_q && zero_q) |->
         (!flags_q[FL_V] && !flags_q[FL_C] && flags_q[FL_X] == $past(flags_in[FL_X], 2)));
   // R7: legal cost is even and at least the short overhead
   p_cost_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !ill_out_q) |-> (!cyc_q[0] && cyc_q >= CYC_W'(SHORT_ADD)));
   // R9: an illegal opcode changes nothing
   p_illegal_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && ill_out_q) |->
         (res_q == $past(dst_val, 2) && flags_q == $past(flags_in, 2) && cyc_q == '0));
endmodule

// File: tb/tb_asl_seq_unit.sv
module tb_asl_seq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] opcode = 16'h0;
   logic [31:0] dst_val = 32'h0;
   logic [31:0] cnt_src = 32'h0;
   logic [4:0]  flags_in = 5'h0;
   logic        busy, done, illegal;
   logic [31:0] result;
   logic [4:0]  flags_out;
   logic [7:0]  cycles;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   asl_seq_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .dst_val(dst_val), .cnt_src(cnt_src), .flags_in(flags_in),
      .busy(busy), .done(done), .illegal(illegal), .result(result),
      .flags_out(flags_out), .cycles(cycles)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mk_op(input logic [2:0] ccc, input logic [1:0] zz, input bit reg_form);
      return {4'hE, ccc, 1'b1, zz, (reg_form ? 3'b100 : 3'b000), 3'b010};
   endfunction

   // expected behaviour from the requirements, one bit per step
   task automatic model(input logic [15:0] op, input logic [31:0] d, input logic [31:0] c,
                        input logic [4:0] fi, output logic [31:0] r, output logic [4:0] fo,
                        output logic [7:0] cy, output logic il);
      int w, n;
      logic [31:0] mask, val;
      logic v, cc, msb, nm;
      il = !(op[15:12] == 4'hE && op[8] && (op[5:3] == 3'b000 || op[5:3] == 3'b100) && op[7:6] != 2'd3);
      if (il) begin r = d; fo = fi; cy = 8'd0; return; end
      w = 8 << op[7:6];
      n = op[5] ? int'(c[5:0]) : ((op[11:9] == 3'd0) ? 8 : int'(op[11:9]));
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      val = d; v = 1'b0; cc = 1'b0;
      for (int i = 0; i < n; i++) begin
         msb = val[w-1];
         val = (val & ~mask) | ((val << 1) & mask);
         nm  = val[w-1];
         v   = v | (msb ^ nm);
         cc  = msb;
      end
      r = val;
      if (n == 0) fo = {fi[4], val[w-1], (val & mask) == 32'h0, 1'b0, 1'b0};
      else        fo = {cc, val[w-1], (val & mask) == 32'h0, v, cc};
      cy = 8'(2 * n + ((w == 32) ? 4 : 2));
   endtask

   task automatic run_op(input string tag, input logic [15:0] op, input logic [31:0] d,
                         input logic [31:0] c, input logic [4:0] fi);
      logic [31:0] er; logic [4:0] ef; logic [7:0] ec; logic ei;
      int wait_n;
      model(op, d, c, fi, er, ef, ec, ei);
      @(negedge clk);
      opcode = op; dst_val = d; cnt_src = c; flags_in = fi; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_n = 0;
      while (!done && wait_n < 300) begin @(negedge clk); wait_n++; end
      chk({tag, " done seen R10"}, 32'(done), 32'd1);
      chk({tag, " result"}, result, er);
      chk({tag, " flags"}, 32'(flags_out), 32'(ef));
      chk({tag, " cycles R7"}, 32'(cycles), 32'(ec));
      chk({tag, " illegal"}, 32'(illegal), 32'(ei));
      @(negedge clk);
      chk({tag, " done one cycle R10"}, 32'(done), 32'd0);
   endtask

   task automatic t_reset();
      chk("R10 reset busy", 32'(busy), 32'd0);
      chk("R10 reset done", 32'(done), 32'd0);
   endtask

   task automatic t_imm_counts();
      run_op("R1 byte imm3", mk_op(3'd3, 2'd0, 0), 32'h0000_0023, 32'h0, 5'h00);
      run_op("R1 word imm7", mk_op(3'd7, 2'd1, 0), 32'h1234_0C05, 32'h0, 5'h1F);
      run_op("R5 long imm1", mk_op(3'd1, 2'd2, 0), 32'hC000_0001, 32'h0, 5'h00);
      run_op("R5 long imm5", mk_op(3'd5, 2'd2, 0), 32'h0800_0000, 32'h0, 5'h00);
   endtask

   task automatic t_imm_eight();
      run_op("R1 byte imm0=8", mk_op(3'd0, 2'd0, 0), 32'h1234_5601, 32'h0, 5'h00);
      chk("R1 imm0 cycles 18", 32'(cycles), 32'd18);
      chk("R8 width count result", result, 32'h1234_5600);
      chk("R8 width count C=bit0", 32'(flags_out[0]), 32'd1);
   endtask

   task automatic t_reg_counts();
      run_op("R2 word mask 0x45", mk_op(3'd2, 2'd1, 1), 32'h0000_0381, 32'hFFFF_FF45, 5'h00);
      chk("R2 masked count cycles", 32'(cycles), 32'd12);
      run_op("R2 long count 63", mk_op(3'd1, 2'd2, 1), 32'h8000_0000, 32'h0000_003F, 5'h10);
      chk("R2 count 63 cycles", 32'(cycles), 32'd130);
   endtask

   task automatic t_zero_count();
      run_op("R6 zero X=1", mk_op(3'd4, 2'd0, 1), 32'h0000_00F0, 32'h0000_0040, 5'h13);
      chk("R6 zero result", result, 32'h0000_00F0);
      chk("R6 zero flags X1 N1 Z0 V0 C0", 32'(flags_out), 32'h18);
      run_op("R6 zero long X=0", mk_op(3'd4, 2'd2, 1), 32'h0000_0000, 32'h0000_0000, 5'h03);
      chk("R6 zero long flags Z", 32'(flags_out), 32'h04);
      chk("R6 zero long cycles", 32'(cycles), 32'd4);
   endtask

   task automatic t_wide();
      run_op("R8 word count16", mk_op(3'd0, 2'd1, 1), 32'hABCD_8001, 32'd16, 5'h00);
      chk("R8 word16 result", result, 32'hABCD_0000);
      chk("R8 word16 C", 32'(flags_out[0]), 32'd1);
      run_op("R8 word count17", mk_op(3'd0, 2'd1, 1), 32'hABCD_8001, 32'd17, 5'h00);
      chk("R8 word17 C=0", 32'(flags_out[0]), 32'd0);
      run_op("R8 long count40", mk_op(3'd0, 2'd2, 1), 32'hFFFF_FFFF, 32'd40, 5'h00);
      chk("R8 long40 flags Z V", 32'(flags_out), 32'h06);
      chk("R8 long40 cycles", 32'(cycles), 32'd84);
   endtask

   task automatic t_upper();
      run_op("R3 byte upper pass", mk_op(3'd1, 2'd0, 0), 32'hDEAD_BE81, 32'h0, 5'h00);
      chk("R3 byte upper result", result, 32'hDEAD_BE02);
      run_op("R3 word upper pass", mk_op(3'd4, 2'd1, 0), 32'h5A5A_1234, 32'h0, 5'h00);
      chk("R3 word upper result", result, 32'h5A5A_2340);
   endtask

   task automatic t_vflag();
      run_op("R4 sticky V", mk_op(3'd3, 2'd0, 0), 32'h0000_003F, 32'h0, 5'h00);
      chk("R4 sticky flags X N V C", 32'(flags_out), 32'h1B);
      run_op("R4 no flip", mk_op(3'd3, 2'd0, 0), 32'h0000_00F0, 32'h0, 5'h00);
      chk("R4 no flip V=0", 32'(flags_out[1]), 32'd0);
   endtask

   task automatic t_illegal();
      run_op("R9 size3", mk_op(3'd2, 2'd3, 0), 32'h1111_2222, 32'h0, 5'h15);
      chk("R9 size3 illegal", 32'(illegal), 32'd1);
      run_op("R9 mode010", 16'hE550, 32'h0000_0081, 32'h0, 5'h0A);
      run_op("R9 group D", 16'hD340, 32'h8765_4321, 32'h0, 5'h1F);
      chk("R9 group flags kept", 32'(flags_out), 32'h1F);
   endtask

   task automatic t_busy();
      logic [31:0] er; logic [4:0] ef; logic [7:0] ec; logic ei;
      int wait_n, extra;
      model(mk_op(3'd0, 2'd2, 1), 32'h0001_0003, 32'd20, 5'h00, er, ef, ec, ei);
      @(negedge clk);
      opcode = mk_op(3'd0, 2'd2, 1); dst_val = 32'h0001_0003; cnt_src = 32'd20; flags_in = 5'h00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 busy after start", 32'(busy), 32'd1);
      repeat (3) @(negedge clk);
      opcode = 16'hD000; dst_val = 32'hFFFF_FFFF; flags_in = 5'h1F; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_n = 0;
      while (!done && wait_n < 300) begin @(negedge clk); wait_n++; end
      chk("R10 ignored start result", result, er);
      chk("R10 ignored start illegal", 32'(illegal), 32'd0);
      chk("R10 ignored start flags", 32'(flags_out), 32'(ef));
      extra = 0;
      repeat (10) begin @(negedge clk); if (done) extra++; end
      chk("R10 no second completion", 32'(extra), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R10 actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_imm_counts();
      t_imm_eight();
      t_reg_counts();
      t_zero_count();
      t_wide();
      t_upper();
      t_vflag();
      t_illegal();
      t_busy();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule